// File: doc/BRIEF.md
# Score-Based Miss Queue Bus Arbiter

This block decides, every clock cycle, which of several per-core miss request queues may use a shared memory bus next. Each queue reports only whether it holds a request. The arbiter grants at most one queue per cycle. The grant is a one-hot vector plus a valid flag, and it is computed combinationally from the current scores and the current not-empty flags.

Fairness comes from a small saturating score kept for each queue. When a grant is made, the winning queue's score rises by a run-time step and every other queue's score falls by one. Among the non-empty queues, the one with the lowest score wins. A queue that issues few requests therefore keeps a low score, so it is served quickly even while the other queues keep the bus saturated.

The step is normally the number of running threads minus one. It is an input so that a system with fewer active threads can use a smaller step.

Top module: `sqarb_top`

## Requirements
- R1: After reset every score is 0, so when all queues are non-empty the first grant goes to queue 0.
- R2: `grant_vld` is 1 exactly when at least one bit of `req_nonempty` is 1, in the same cycle.
- R3: On a clock edge with a grant, the winner's score becomes min(15, score + `step_x`).
- R4: On a clock edge with a grant, every queue that did not win, whether empty or not, has its score become max(0, score - 1).
- R5: On a clock edge with no non-empty queue, no score changes.
- R6: The grant goes to the non-empty queue with the lowest score. When several non-empty queues share that lowest score, the one with the lowest index wins.
- R7: `grant` has at most one bit set, and bit i of `grant` is set only if bit i of `req_nonempty` is set. Bit i of each vector belongs to queue i.
- R8: `step_x` is sampled on every granting edge and may be any value from 0 to 3. With 0, the winner's score stays unchanged while the losers' scores still decrease.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_nonempty | input | 4 | Not-empty flag per queue; bit i is queue i |
| step_x | input | 2 | Amount added to the winner's score |
| grant | output | 4 | One-hot grant; bit i is queue i |
| grant_vld | output | 1 | A grant is made this cycle |

## Verification
The bench drives a long saturation phase in which a single queue is served until its score is pinned at 15. It then releases the other queues and checks that they win at once. A design that wrapped the 4-bit score instead of clamping it would hand the pinned queue an early win. The bench also holds queues idle until their scores reach 0 and confirms they stay there, which exposes a decrement that underflows to 15. Ties among equal scores and idle cycles with all queues empty are visited on purpose: a wrong tie order, or an update applied during an idle cycle, shifts every later grant away from what the bench model predicts. A step of 0 is also mixed in, which catches a design that hard-wires the increment.

// File: rtl/sqarb_pkg.sv
package sqarb_pkg;
   localparam int unsigned SQARB_MAX_REQ = 32;

   function automatic int unsigned sqarb_idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/sqarb_score_cell.sv
module sqarb_score_cell #(
   parameter int unsigned SCORE_W = 4,
   parameter int unsigned STEP_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               update_en,
   input  logic               won,
   input  logic [STEP_W-1:0]  step,
   output logic [SCORE_W-1:0] score
);
   localparam int unsigned SUM_W = ((SCORE_W > STEP_W) ? SCORE_W : STEP_W) + 1;
   localparam logic [SUM_W-1:0] TOP = SUM_W'((1 << SCORE_W) - 1);

   logic [SUM_W-1:0]   raised;
   logic [SCORE_W-1:0] up_val;
   logic [SCORE_W-1:0] down_val;

   always_comb begin
      raised   = SUM_W'(score) + SUM_W'(step);
      up_val   = (raised > TOP) ? TOP[SCORE_W-1:0] : raised[SCORE_W-1:0];
      down_val = (score == '0) ? '0 : score - SCORE_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         score <= '0;
      else if (update_en)
         score <= won ? up_val : down_val;
   end

   // R3: a winner never loses score and lands on the sum or the ceiling
   a_r3_winner_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (update_en && won) |=> (score >= $past(score)) &&
         ((score == TOP[SCORE_W-1:0]) ||
          (SUM_W'(score) == SUM_W'($past(score)) + SUM_W'($past(step)))));

   // R4: a loser drops by one, or rests at zero
   a_r4_loser_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (update_en && !won) |=> ($past(score) == '0) ? (score == '0)
                                                   : (score == $past(score) - SCORE_W'(1)));

   // R5: without an update the score holds
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !update_en |=> $stable(score));
endmodule

// File: rtl/sqarb_min_pick.sv
module sqarb_min_pick #(
   parameter int unsigned NUM_REQ = 4,
   parameter int unsigned SCORE_W = 4
) (
   input  logic [NUM_REQ-1:0]              req,
   input  logic [NUM_REQ-1:0][SCORE_W-1:0] scores,
   output logic [NUM_REQ-1:0]              pick,
   output logic                            any
);
   localparam int unsigned IDX_W = sqarb_pkg::sqarb_idx_w(NUM_REQ);

   logic [IDX_W-1:0]   best_idx;
   logic [SCORE_W-1:0] best_score;
   logic               found;

   always_comb begin
      best_idx   = '0;
      best_score = '1;
      found      = 1'b0;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (req[i] && (!found || scores[i] < best_score)) begin
            best_idx   = IDX_W'(i);
            best_score = scores[i];
            found      = 1'b1;
         end
      end
      for (int j = 0; j < NUM_REQ; j++)
         pick[j] = found && (best_idx == IDX_W'(j));
      any = found;
   end

   // R6: no other requester holds a strictly lower score, nor an equal score at a lower index
   always_comb begin
      for (int k = 0; k < NUM_REQ; k++) begin
         if (found && req[k]) begin
            a_r6_lowest: assert ((scores[k] > best_score) ||
                                 (scores[k] == best_score && IDX_W'(k) >= best_idx));
         end
      end
   end
endmodule

// File: rtl/sqarb_top.sv
module sqarb_top #(
   parameter int unsigned NUM_REQ = 4,
   parameter int unsigned SCORE_W = 4
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic [NUM_REQ-1:0]                          req_nonempty,
   input  logic [sqarb_pkg::sqarb_idx_w(NUM_REQ)-1:0]  step_x,
   output logic [NUM_REQ-1:0]                          grant,
   output logic                                        grant_vld
);
   localparam int unsigned STEP_W = sqarb_pkg::sqarb_idx_w(NUM_REQ);

   if (NUM_REQ < 2 || NUM_REQ > sqarb_pkg::SQARB_MAX_REQ) begin : g_bad_num
      $error("sqarb_top: NUM_REQ out of range");
   end
   if (SCORE_W < STEP_W) begin : g_bad_score
      $error("sqarb_top: SCORE_W too narrow for the step");
   end

   logic [NUM_REQ-1:0][SCORE_W-1:0] scores;
   logic [NUM_REQ-1:0]              pick;
   logic                            any;

   sqarb_min_pick #(.NUM_REQ(NUM_REQ), .SCORE_W(SCORE_W)) u_pick (
      .req    (req_nonempty),
      .scores (scores),
      .pick   (pick),
      .any    (any)
   );

   for (genvar q = 0; q < NUM_REQ; q++) begin : g_cell
      sqarb_score_cell #(.SCORE_W(SCORE_W), .STEP_W(STEP_W)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .update_en (any),
         .won       (pick[q]),
         .step      (step_x),
         .score     (scores[q])
      );
   end

   assign grant     = pick;
   assign grant_vld = any;

   // R7: grant is one-hot or zero and never reaches an empty queue
   a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
   a_r7_only_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req_nonempty) == '0);
   // R2: valid tracks presence of any request
   a_r2_valid: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld == (req_nonempty != '0));
   // R5: an idle cycle leaves every score untouched
   a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_nonempty == '0) |=> $stable(scores));
endmodule

// File: tb/sqarb_top_test.sv
module sqarb_top_test;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req_nonempty = '0;
   logic [1:0]   step_x = 2'd3;
   logic [N-1:0] grant;
   logic         grant_vld;

   int n_checks = 0;
   int n_bad = 0;
   int model [N];

   always #4 clk = ~clk;

   sqarb_top uut (
      .clk(clk), .rst_n(rst_n), .req_nonempty(req_nonempty),
      .step_x(step_x), .grant(grant), .grant_vld(grant_vld)
   );

   function automatic logic [N-1:0] exp_grant(input logic [N-1:0] r);
      int best = -1;
      for (int i = 0; i < N; i++)
         if (r[i] && (best < 0 || model[i] < model[best])) best = i;
      return (best < 0) ? '0 : (N'(1) << best);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // apply one cycle: drive at negedge, check, then advance model to next edge
   task automatic cycle(input logic [N-1:0] r, input logic [1:0] x, input string tag);
      logic [N-1:0] eg;
      @(negedge clk);
      req_nonempty = r;
      step_x = x;
      #1;
      eg = exp_grant(r);
      check({tag, " R6/R7 grant"}, 32'(grant), 32'(eg));
      check({tag, " R2 valid"}, 32'(grant_vld), 32'(r != '0));
      if (r != '0) begin
         for (int i = 0; i < N; i++) begin
            if (eg[i]) model[i] = (model[i] + x > 15) ? 15 : model[i] + x;
            else       model[i] = (model[i] == 0) ? 0 : model[i] - 1;
         end
      end
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < N; i++) model[i] = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R2 reset valid idle", 32'(grant_vld), 32'd0);
      rst_n = 1'b1;
      // R1: all tied at zero, queue 0 first
      cycle(4'b1111, 2'd3, "R1 reset tie");
      // R6 tie rotation
      repeat (6) cycle(4'b1111, 2'd3, "R6 full load");
      // R5 idle cycles, then compare
      repeat (3) cycle(4'b0000, 2'd3, "R5 idle");
      cycle(4'b1111, 2'd3, "R5 after idle");
      // R3 saturation: queue 0 alone, score pins at 15
      repeat (10) cycle(4'b0001, 2'd3, "R3 saturate");
      // R4 others floored at 0; release: queue 1 should win
      repeat (3) cycle(4'b1111, 2'd1, "R4 floor release");
      // R8 step zero: winner unchanged
      repeat (8) cycle(4'b0110, 2'd0, "R8 step zero");
      repeat (4) cycle(4'b1111, 2'd2, "R8 step two");
      // R7 sparse patterns
      cycle(4'b1000, 2'd3, "R7 single high");
      cycle(4'b0100, 2'd3, "R7 single mid");
      // random mix
      for (int k = 0; k < 3000; k++) begin
         logic [N-1:0] r = N'($urandom);
         logic [1:0]   x = 2'($urandom);
         if ($urandom % 8 == 0) r = '0;
         cycle(r, x, "R6 random");
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_bad);
      $finish;
   end
endmodule